// File: doc/BRIEF.md
# Interrupt Presentation Priority Context

This block holds the priority state that one hardware thread uses to decide whether a pending interrupt is presented to the processor. It records pending priorities as a one-hot-per-level bitmap. The most favoured pending level is derived from that bitmap. The block compares this level against the thread's current priority mask. When the pending level wins, it sets an exception flag that drives the processor's interrupt line.

A smaller priority number is more favoured. Delivery logic posts priorities on the notification port. Software moves the mask through the mask write port. Software takes an interrupt by pulsing the accept request. Accept is an atomic test-and-clear. It hands back the status seen before the update, together with the new mask. Because one level has only one bitmap bit, a refill port lets software mark levels pending again when more work of the same priority is queued.

Top module: `irq_presenter`

## Requirements
- R1: After reset, the pending bitmap and status are empty and the mask is 0, which blocks every level. The interrupt line is low, `acc_valid` and `ntf_err` are low, and an accept returns 16'h0000. A level-0 notification then leaves the line low.
- R2: Level p (0..7) occupies bitmap bit 7-p. The pending level is the index of the highest set bit counted from bit 7, or 8'hFF when the bitmap is empty. The exception condition is pending level strictly less than the mask, so a notification equal to the mask does not raise the line.
- R3: A valid notification sets its level's bit and then runs the exception check. When the check passes, status bit 7 (the exception flag) is set and `irq_o` is high on the next clock.
- R4: A mask write replaces the mask and runs the exception check. Raising the mask above an already pending level raises `irq_o` on the next clock.
- R5: An accept while the exception flag is set does the following: the mask takes the pending level, that level's bit is cleared, the pending level is re-derived, and the flag and `irq_o` drop. The returned word is {status before update, mask after update}, so the upper byte is 8'h80.
- R6: An accept while the flag is clear changes no state and returns {8'h00, current mask}.
- R7: After an accept, the remaining bitmap bits stay pending. A later check presents the next most favoured level.
- R8: A notification with a level of 8 or above, including 8'hFF, leaves the bitmap and the line unchanged. It pulses `ntf_err` high for exactly one cycle, one clock later.
- R9: A refill write ORs `ipb_set_mask` into the bitmap using the R2 bit layout, then runs the exception check.
- R10: When an accept and a notification arrive in the same cycle, the accept is applied first. The notification and its check follow on the updated state.
- R11: Repeated notifications of one level share one bit, and one accept consumes them all. Only a refill makes the level pending again.
- R12: `acc_valid` and `acc_word` are registered. They are valid exactly one clock after `acc_req` and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ntf_valid | input | 1 | Notification strobe |
| ntf_prio | input | 8 | Priority of the notification |
| cppr_wr | input | 1 | Mask write strobe |
| cppr_wdata | input | 8 | New mask value |
| ipb_set_valid | input | 1 | Refill strobe |
| ipb_set_mask | input | 8 | Bitmap bits to set again |
| acc_req | input | 1 | Accept request |
| irq_o | output | 1 | Interrupt line to the processor |
| acc_valid | output | 1 | Accept result valid |
| acc_word | output | 16 | {status before, mask after} |
| ntf_err | output | 1 | Invalid-priority notification flag |

## Verification
Every result is one register stage away from its stimulus. `irq_o`, `ntf_err`, `acc_valid` and `acc_word` all change on the edge that samples the request. The bench drives each request on a falling edge and holds it through one rising edge. It then reads the outputs on the next falling edge, which is the cycle they are due. One cycle later it checks that the one-cycle pulses have dropped again. Chained scenarios track the mask across accepts, so each returned word is predicted from the requirement rules alone.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
   localparam int unsigned BYTE_W = 8;
   localparam logic [BYTE_W-1:0] PRIO_NONE = 8'hFF;

   typedef struct packed {
      logic [BYTE_W-1:0] nsr;
      logic [BYTE_W-1:0] cppr;
   } acc_word_t;
endpackage

// File: rtl/irq_prio_mask.sv
module irq_prio_mask #(
   parameter int unsigned NUM_PRIO = 8
) (
   input  logic [7:0]          prio,
   output logic [NUM_PRIO-1:0] mask,
   output logic                in_range
);
   // level 0 sits in the top bit, the least favoured level in bit 0
   for (genvar i = 0; i < NUM_PRIO; i++) begin : g_bit
      assign mask[NUM_PRIO-1-i] = (prio == 8'(i));
   end
   assign in_range = (prio < 8'(NUM_PRIO));
endmodule

// File: rtl/irq_prio_lzc.sv
module irq_prio_lzc
   import irq_prio_pkg::*;
#(
   parameter int unsigned NUM_PRIO = 8
) (
   input  logic [NUM_PRIO-1:0] ipb,
   output logic [BYTE_W-1:0]   pipr
);
   // leading-zero count from the top bit; empty bitmap yields the idle code
   always_comb begin
      pipr = PRIO_NONE;
      for (int i = NUM_PRIO - 1; i >= 0; i--) begin
         if (ipb[NUM_PRIO-1-i]) pipr = 8'(i);
      end
   end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
   import irq_prio_pkg::*;
#(
   parameter int unsigned PRIO_W = 3,
   parameter int unsigned EO_BIT = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ntf_valid,
   input  logic [7:0]  ntf_prio,
   input  logic        cppr_wr,
   input  logic [7:0]  cppr_wdata,
   input  logic        ipb_set_valid,
   input  logic [7:0]  ipb_set_mask,
   input  logic        acc_req,
   output logic        irq_o,
   output logic        acc_valid,
   output logic [15:0] acc_word,
   output logic        ntf_err
);
   localparam int unsigned NUM_PRIO = 1 << PRIO_W;

   if (PRIO_W < 1 || PRIO_W > 7) begin : g_bad_prio_w
      $error("PRIO_W must lie in 1..7 so the idle code stays out of range");
   end
   if (EO_BIT >= BYTE_W) begin : g_bad_eo
      $error("EO_BIT must address a bit of the status byte");
   end
   if (NUM_PRIO != BYTE_W) begin : g_bad_set_w
      $error("refill port is one byte wide; PRIO_W must give 8 levels");
   end

   logic [NUM_PRIO-1:0] ipb_q, ipb_a, ipb_n;
   logic [BYTE_W-1:0]   cppr_q, cppr_a, cppr_n;
   logic [BYTE_W-1:0]   nsr_q, nsr_a, nsr_n;
   logic [BYTE_W-1:0]   pipr_q, pipr_n;
   logic [NUM_PRIO-1:0] ntf_mask, acc_mask;
   logic                ntf_in_range, acc_in_range;
   logic                ntf_ok, check_ev, taking;
   acc_word_t           word_q;
   logic                acc_valid_q, err_q;

   // decoders: incoming notification and the level being accepted
   irq_prio_mask #(.NUM_PRIO(NUM_PRIO)) u_ntf_mask (
      .prio(ntf_prio), .mask(ntf_mask), .in_range(ntf_in_range));
   irq_prio_mask #(.NUM_PRIO(NUM_PRIO)) u_acc_mask (
      .prio(pipr_q), .mask(acc_mask), .in_range(acc_in_range));

   // encoders: current pending level and the one after this cycle's updates
   irq_prio_lzc #(.NUM_PRIO(NUM_PRIO)) u_pipr_cur (.ipb(ipb_q), .pipr(pipr_q));
   irq_prio_lzc #(.NUM_PRIO(NUM_PRIO)) u_pipr_nxt (.ipb(ipb_n), .pipr(pipr_n));

   assign ntf_ok   = ntf_valid && ntf_in_range;
   assign taking   = acc_req && nsr_q[EO_BIT] && acc_in_range;
   assign check_ev = ntf_ok || cppr_wr || ipb_set_valid;

   always_comb begin
      // stage 1: accept (test-and-clear)
      ipb_a  = ipb_q;
      cppr_a = cppr_q;
      nsr_a  = nsr_q;
      if (taking) begin
         cppr_a        = pipr_q;
         ipb_a         = ipb_q & ~acc_mask;
         nsr_a[EO_BIT] = 1'b0;
      end
      // stage 2: mask write, notification, refill
      cppr_n = cppr_wr ? cppr_wdata : cppr_a;
      ipb_n  = ipb_a;
      if (ntf_ok)        ipb_n = ipb_n | ntf_mask;
      if (ipb_set_valid) ipb_n = ipb_n | ipb_set_mask[NUM_PRIO-1:0];
      // stage 3: exception check
      nsr_n = nsr_a;
      if (check_ev && (pipr_n < cppr_n)) nsr_n[EO_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ipb_q       <= '0;
         cppr_q      <= '0;
         nsr_q       <= '0;
         word_q      <= '0;
         acc_valid_q <= 1'b0;
         err_q       <= 1'b0;
      end else begin
         ipb_q       <= ipb_n;
         cppr_q      <= cppr_n;
         nsr_q       <= nsr_n;
         acc_valid_q <= acc_req;
         err_q       <= ntf_valid && !ntf_in_range;
         if (acc_req) begin
            word_q.nsr  <= nsr_q;
            word_q.cppr <= cppr_a;
         end
      end
   end

   assign irq_o     = nsr_q[EO_BIT];
   assign acc_valid = acc_valid_q;
   assign acc_word  = acc_valid_q ? word_q : 16'h0000;
   assign ntf_err   = err_q;
endmodule

// File: rtl/irq_presenter_chk.sv
module irq_presenter_chk #(
   parameter int unsigned NUM_PRIO = 8,
   parameter int unsigned EO_BIT   = 7
) (
   input logic        clk,
   input logic        rst_n,
   input logic        ntf_valid,
   input logic [7:0]  ntf_prio,
   input logic        cppr_wr,
   input logic        ipb_set_valid,
   input logic        acc_req,
   input logic        irq_o,
   input logic        acc_valid,
   input logic [15:0] acc_word,
   input logic        ntf_err
);
   logic bad_ntf;
   assign bad_ntf = ntf_valid && (ntf_prio >= 8'(NUM_PRIO));

   // R12: result valid exactly one clock after the request
   a_r12_acc_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      acc_req |=> acc_valid);
   a_r12_acc_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_req |=> !acc_valid);
   // R8: invalid level flagged for one cycle, valid ones never flagged
   a_r8_err_flag: assert property (@(posedge clk) disable iff (!rst_n)
      bad_ntf |=> ntf_err);
   a_r8_err_only: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_ntf |=> !ntf_err);
   // R8: an invalid notification alone leaves the line as it was
   a_r8_line_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_ntf && !cppr_wr && !ipb_set_valid && !acc_req) |=> $stable(irq_o));
   // R5: a lone accept always drops the line
   a_r5_accept_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_req && !ntf_valid && !cppr_wr && !ipb_set_valid) |=> !irq_o);
   // R5: returned status carries the flag as it stood at the request
   a_r5_word_status: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |-> (acc_word[8+EO_BIT] == $past(irq_o)));
   // R3: the line only rises after a notification, mask write or refill
   a_r3_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(ntf_valid || cppr_wr || ipb_set_valid));
endmodule

bind irq_presenter irq_presenter_chk #(.NUM_PRIO(NUM_PRIO), .EO_BIT(EO_BIT)) u_chk (
   .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_prio(ntf_prio),
   .cppr_wr(cppr_wr), .ipb_set_valid(ipb_set_valid), .acc_req(acc_req),
   .irq_o(irq_o), .acc_valid(acc_valid), .acc_word(acc_word), .ntf_err(ntf_err));

// File: tb/test_irq_presenter.sv
`timescale 1ns/1ps
module test_irq_presenter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ntf_valid = 1'b0;
   logic [7:0]  ntf_prio = '0;
   logic        cppr_wr = 1'b0;
   logic [7:0]  cppr_wdata = '0;
   logic        ipb_set_valid = 1'b0;
   logic [7:0]  ipb_set_mask = '0;
   logic        acc_req = 1'b0;
   logic        irq_o, acc_valid, ntf_err;
   logic [15:0] acc_word;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;   // 200 MHz

   irq_presenter i_irq_presenter (
      .clk(clk), .rst_n(rst_n), .ntf_valid(ntf_valid), .ntf_prio(ntf_prio),
      .cppr_wr(cppr_wr), .cppr_wdata(cppr_wdata), .ipb_set_valid(ipb_set_valid),
      .ipb_set_mask(ipb_set_mask), .acc_req(acc_req), .irq_o(irq_o),
      .acc_valid(acc_valid), .acc_word(acc_word), .ntf_err(ntf_err));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic notify(input logic [7:0] p);
      ntf_valid = 1'b1; ntf_prio = p;
      @(negedge clk);
      ntf_valid = 1'b0;
   endtask

   task automatic write_mask(input logic [7:0] m);
      cppr_wr = 1'b1; cppr_wdata = m;
      @(negedge clk);
      cppr_wr = 1'b0;
   endtask

   task automatic refill(input logic [7:0] m);
      ipb_set_valid = 1'b1; ipb_set_mask = m;
      @(negedge clk);
      ipb_set_valid = 1'b0;
   endtask

   task automatic accept(input string req, input logic [15:0] exp);
      acc_req = 1'b1;
      @(negedge clk);
      acc_req = 1'b0;
      chk({req, " acc_valid"}, 16'(acc_valid), 16'd1);
      chk({req, " word"}, acc_word, exp);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 irq", 16'(irq_o), 16'd0);
      chk("R1 acc_valid", 16'(acc_valid), 16'd0);
      chk("R1 err", 16'(ntf_err), 16'd0);
      notify(8'd0);
      chk("R1 masked level 0", 16'(irq_o), 16'd0);
      accept("R1", 16'h0000);
      @(negedge clk);
      chk("R12 valid drops", 16'(acc_valid), 16'd0);
   endtask

   task automatic t_compare();
      do_reset();
      write_mask(8'd3);
      chk("R4 empty stays low", 16'(irq_o), 16'd0);
      notify(8'd3);
      chk("R2 equal level no irq", 16'(irq_o), 16'd0);
      notify(8'd2);
      chk("R3 favoured level irq", 16'(irq_o), 16'd1);
      accept("R5", 16'h8002);
      chk("R5 line dropped", 16'(irq_o), 16'd0);
      accept("R6", 16'h0002);
      write_mask(8'd4);
      chk("R4 R7 next level presented", 16'(irq_o), 16'd1);
      accept("R7", 16'h8003);
      accept("R6 empty", 16'h0003);
   endtask

   task automatic t_invalid();
      do_reset();
      write_mask(8'hFF);
      notify(8'hFF);
      chk("R8 err FF", 16'(ntf_err), 16'd1);
      chk("R8 irq FF", 16'(irq_o), 16'd0);
      @(negedge clk);
      chk("R8 err one cycle", 16'(ntf_err), 16'd0);
      notify(8'd8);
      chk("R8 err 8", 16'(ntf_err), 16'd1);
      chk("R8 irq 8", 16'(irq_o), 16'd0);
      accept("R8 nothing pending", 16'h00FF);
      notify(8'd7);
      chk("R8 valid level no err", 16'(ntf_err), 16'd0);
      chk("R2 level 7 under FF", 16'(irq_o), 16'd1);
   endtask

   task automatic t_shared();
      do_reset();
      write_mask(8'hFF);
      notify(8'd4);
      notify(8'd4);
      chk("R11 irq", 16'(irq_o), 16'd1);
      accept("R11 first", 16'h8004);
      accept("R11 collapsed", 16'h0004);
      write_mask(8'hFF);
      chk("R11 nothing left", 16'(irq_o), 16'd0);
      refill(8'h08);   // level 4 is bit 3
      chk("R9 refill irq", 16'(irq_o), 16'd1);
      accept("R9", 16'h8004);
   endtask

   task automatic t_same_cycle();
      do_reset();
      write_mask(8'hFF);
      notify(8'd3);
      chk("R10 pre irq", 16'(irq_o), 16'd1);
      acc_req = 1'b1; ntf_valid = 1'b1; ntf_prio = 8'd1;
      @(negedge clk);
      acc_req = 1'b0; ntf_valid = 1'b0;
      chk("R10 word", acc_word, 16'h8003);
      chk("R10 irq re-raised", 16'(irq_o), 16'd1);
      accept("R10 second", 16'h8001);
      chk("R10 line low", 16'(irq_o), 16'd0);
      accept("R10 empty", 16'h0001);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_compare();
      t_invalid();
      t_shared();
      t_same_cycle();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule